// File: doc/BRIEF.md
# Control-Endpoint Receive FIFO with SETUP Overwrite Lock

This block is the receive buffer of a control-capable USB endpoint. It holds one data packet of up to eight bytes. The serial engine writes the packet one byte at a time, writes the byte count, and then commits the packet with an acknowledge or drops it with an error. Firmware reads the committed bytes in order through a data port. It reads the count, and it releases the packet with a read-complete strobe, which makes room for the next packet.

A SETUP token must always get through, even when firmware is part way through reading an older packet. For this the block has two lock flags. The start-lock flag is raised by the SETUP token and lowered when the setup stage is acknowledged. The end-lock flag is raised at that same acknowledge and stays up until firmware clears it. While either flag is up, the buffer is frozen for the CPU: full reads low, reads return zero and move no pointer, and read-complete does nothing.

The controller is a four-state machine:
- OPEN: filling, nothing readable.
- HELD: a committed packet is readable.
- SETUP: the start-lock flag is up and SETUP bytes are arriving.
- LOCK: the end-lock flag is up.

The transitions are:
- OPEN→HELD on acknowledge.
- HELD→OPEN on read-complete.
- SETUP→LOCK on acknowledge.
- LOCK→HELD when firmware clears the end-lock flag.
- Any state→SETUP on a SETUP token.
- Any state→OPEN on flush.

Top module: `usb_rx_setup_fifo`

## Requirements
- R1: After reset, empty is 1, and full, overrun, underrun, both lock flags and the count output are all 0.
- R2: Bytes written by the engine and committed with an acknowledge set full. Each read strobe puts the next byte, in write order, on the data output one clock later. The count output shows the last written 4-bit count while full is 1, and 0 otherwise. Empty is 1 once every stored byte has been read.
- R3: An error in place of an acknowledge rolls the write pointer back to the start of the packet and leaves full at 0. The next packet is read from its own first byte.
- R4: An engine write while the packet is held or locked sets the sticky overrun flag and stores nothing. Overrun is cleared only by a SETUP token or a flush.
- R5: A CPU read when no byte is readable and no lock flag is up sets the sticky underrun flag, returns 0 and does not move the read pointer. The clear-underrun strobe clears the flag.
- R6: Read-complete while a packet is held and both lock flags are 0 clears full, sets empty, and makes the buffer ready for a new packet.
- R7: A SETUP token in any state raises the start-lock flag on the next clock. On that clock it also clears full and overrun and resets both pointers. It takes priority over a flush in the same cycle.
- R8: An acknowledge while the start-lock flag is up lowers it and raises the end-lock flag in the same clock. Full stays 0.
- R9: While either lock flag is up, CPU reads return 0, move no pointer and do not set underrun, and read-complete has no effect.
- R10: When firmware clears the end-lock flag, full becomes 1 and the SETUP bytes are readable from the first one.
- R11: A flush (with no SETUP token) sets empty and clears full, overrun, underrun and both lock flags on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eng_wr_en | input | 1 | Engine byte write strobe |
| eng_wr_data | input | 8 | Engine byte to store |
| eng_cnt_wr | input | 1 | Engine byte-count write strobe |
| eng_cnt | input | 4 | Byte count of the packet |
| eng_ack | input | 1 | Packet acknowledged (commit) |
| eng_err | input | 1 | Packet ended in error (roll back) |
| eng_setup | input | 1 | SETUP token seen |
| cpu_rd_en | input | 1 | CPU data read strobe |
| cpu_rd_done | input | 1 | CPU read-complete release strobe |
| cpu_flush | input | 1 | CPU flush strobe |
| cpu_clr_end | input | 1 | CPU clears the end-lock flag |
| cpu_clr_unrun | input | 1 | CPU clears the underrun flag |
| cpu_rd_data | output | 8 | Byte returned by the last read strobe |
| cpu_cnt | output | 4 | Byte count while full, else 0 |
| full | output | 1 | Committed packet readable |
| empty | output | 1 | No readable byte left |
| ovrun | output | 1 | Sticky overrun flag |
| unrun | output | 1 | Sticky underrun flag |
| start_lock | output | 1 | Start-lock flag (SETUP stage running) |
| end_lock | output | 1 | End-lock flag (awaiting firmware clear) |

## Verification
A controller stuck in the wrong state shows at the ports on the very next clock. The lock flags and full are decoded straight from the state, so a missed SETUP shows full still high or start-lock still low one cycle after the token. A wrong read pointer shows on the first data byte read after a release, a rollback or an end-lock clear: that byte differs from the first byte written. It also shows in when empty rises. A lost sticky flag is seen as soon as the next event that should leave it alone has happened.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;
    typedef enum logic [1:0] {
        ST_OPEN  = 2'd0,
        ST_HELD  = 2'd1,
        ST_SETUP = 2'd2,
        ST_LOCK  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/usbrx_store.sv
module usbrx_store #(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          store_en,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_clr,
    input  logic          rd_en,
    input  logic          rd_zero,
    input  logic          rd_clr,
    input  logic          cnt_we,
    input  logic [CW-1:0] cnt_in,
    input  logic          cnt_clr,
    output logic          have_data,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] cnt_q
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic          room;

    assign room      = (wr_ptr < PW'(DEPTH));
    assign have_data = (rd_ptr < wr_ptr);

    always_ff @(posedge clk) begin
        if (store_en && room && !wr_clr)
            mem[wr_ptr[AW-1:0]] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_ptr <= '0;
        else if (wr_clr)
            wr_ptr <= '0;
        else if (store_en && room)
            wr_ptr <= wr_ptr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr  <= '0;
            rd_data <= '0;
        end else if (rd_clr) begin
            rd_ptr  <= '0;
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= mem[rd_ptr[AW-1:0]];
            rd_ptr  <= rd_ptr + 1'b1;
        end else if (rd_zero) begin
            rd_data <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || cnt_clr)
            cnt_q <= '0;
        else if (cnt_we)
            cnt_q <= cnt_in;
    end
endmodule

// File: rtl/usbrx_ctrl.sv
module usbrx_ctrl
    import usbrx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic eng_wr_en,
    input  logic eng_cnt_wr,
    input  logic eng_ack,
    input  logic eng_err,
    input  logic eng_setup,
    input  logic cpu_rd_en,
    input  logic cpu_rd_done,
    input  logic cpu_flush,
    input  logic cpu_clr_end,
    input  logic cpu_clr_unrun,
    input  logic have_data,
    output logic store_en,
    output logic wr_clr,
    output logic rd_en,
    output logic rd_zero,
    output logic rd_clr,
    output logic cnt_we,
    output logic cnt_clr,
    output logic full,
    output logic readable,
    output logic start_lock,
    output logic end_lock,
    output logic ovrun,
    output logic unrun
);
    rx_state_e state_q, state_d;
    logic setup_ev, flush_ev, quiet, fill_st, ovr_hit, und_hit, release_ev;

    assign setup_ev = eng_setup;
    assign flush_ev = cpu_flush && !eng_setup;
    assign quiet    = !setup_ev && !flush_ev;

    always_comb begin
        state_d = state_q;
        if (setup_ev) begin
            state_d = ST_SETUP;
        end else if (flush_ev) begin
            state_d = ST_OPEN;
        end else begin
            unique case (state_q)
                ST_OPEN:  if (eng_ack && !eng_err) state_d = ST_HELD;
                ST_HELD:  if (cpu_rd_done)         state_d = ST_OPEN;
                ST_SETUP: if (eng_ack && !eng_err) state_d = ST_LOCK;
                ST_LOCK:  if (cpu_clr_end)         state_d = ST_HELD;
                default:                           state_d = ST_OPEN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_OPEN;
        else
            state_q <= state_d;
    end

    always_comb begin
        fill_st    = 1'b0;
        full       = 1'b0;
        start_lock = 1'b0;
        end_lock   = 1'b0;
        unique case (state_q)
            ST_OPEN:  fill_st    = 1'b1;
            ST_HELD:  full       = 1'b1;
            ST_SETUP: begin fill_st = 1'b1; start_lock = 1'b1; end
            ST_LOCK:  end_lock   = 1'b1;
            default:  fill_st    = 1'b0;
        endcase
        readable   = full && have_data;
        release_ev = full && cpu_rd_done && quiet;
        store_en   = eng_wr_en && fill_st && quiet && !eng_err;
        ovr_hit    = eng_wr_en && !fill_st && quiet;
        cnt_we     = eng_cnt_wr && fill_st && quiet && !eng_err;
        rd_en      = cpu_rd_en && readable && quiet;
        und_hit    = cpu_rd_en && !readable && !start_lock && !end_lock && quiet;
        rd_zero    = cpu_rd_en && !rd_en;
        rd_clr     = setup_ev || flush_ev || release_ev;
        wr_clr     = rd_clr || (fill_st && eng_err);
        cnt_clr    = wr_clr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovrun <= 1'b0;
            unrun <= 1'b0;
        end else begin
            if (setup_ev || flush_ev)
                ovrun <= 1'b0;
            else if (ovr_hit)
                ovrun <= 1'b1;
            if (flush_ev || cpu_clr_unrun)
                unrun <= 1'b0;
            else if (und_hit)
                unrun <= 1'b1;
        end
    end
endmodule

// File: rtl/usb_rx_setup_fifo.sv
module usb_rx_setup_fifo #(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          eng_wr_en,
    input  logic [DW-1:0] eng_wr_data,
    input  logic          eng_cnt_wr,
    input  logic [CW-1:0] eng_cnt,
    input  logic          eng_ack,
    input  logic          eng_err,
    input  logic          eng_setup,
    input  logic          cpu_rd_en,
    input  logic          cpu_rd_done,
    input  logic          cpu_flush,
    input  logic          cpu_clr_end,
    input  logic          cpu_clr_unrun,
    output logic [DW-1:0] cpu_rd_data,
    output logic [CW-1:0] cpu_cnt,
    output logic          full,
    output logic          empty,
    output logic          ovrun,
    output logic          unrun,
    output logic          start_lock,
    output logic          end_lock
);
    logic store_en, wr_clr, rd_en, rd_zero, rd_clr, cnt_we, cnt_clr;
    logic have_data, readable;
    logic [CW-1:0] cnt_q;

    usbrx_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .eng_wr_en(eng_wr_en), .eng_cnt_wr(eng_cnt_wr), .eng_ack(eng_ack),
        .eng_err(eng_err), .eng_setup(eng_setup),
        .cpu_rd_en(cpu_rd_en), .cpu_rd_done(cpu_rd_done), .cpu_flush(cpu_flush),
        .cpu_clr_end(cpu_clr_end), .cpu_clr_unrun(cpu_clr_unrun),
        .have_data(have_data),
        .store_en(store_en), .wr_clr(wr_clr), .rd_en(rd_en), .rd_zero(rd_zero),
        .rd_clr(rd_clr), .cnt_we(cnt_we), .cnt_clr(cnt_clr),
        .full(full), .readable(readable), .start_lock(start_lock),
        .end_lock(end_lock), .ovrun(ovrun), .unrun(unrun)
    );

    usbrx_store #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .store_en(store_en), .wr_data(eng_wr_data), .wr_clr(wr_clr),
        .rd_en(rd_en), .rd_zero(rd_zero), .rd_clr(rd_clr),
        .cnt_we(cnt_we), .cnt_in(eng_cnt), .cnt_clr(cnt_clr),
        .have_data(have_data), .rd_data(cpu_rd_data), .cnt_q(cnt_q)
    );

    assign empty   = !readable;
    assign cpu_cnt = full ? cnt_q : '0;
endmodule

// File: rtl/usb_rx_setup_fifo_chk.sv
module usb_rx_setup_fifo_chk (
    input logic clk,
    input logic rst_n,
    input logic eng_setup,
    input logic cpu_flush,
    input logic cpu_rd_en,
    input logic cpu_rd_done,
    input logic cpu_clr_end,
    input logic full,
    input logic empty,
    input logic ovrun,
    input logic unrun,
    input logic start_lock,
    input logic end_lock
);
    // R7: SETUP token locks and empties on the next clock
    assert_setup_locks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_setup |=> (start_lock && !full && !ovrun && empty));

    // R8: end-lock rises only straight out of the start-lock stage
    assert_end_after_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(end_lock) |-> ($past(start_lock) && !start_lock && !full));

    // R4: overrun is sticky until SETUP or flush
    assert_ovrun_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovrun && !eng_setup && !cpu_flush) |=> ovrun);

    // R9: read-complete and reads do not free a locked buffer
    assert_lock_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (end_lock && !eng_setup && !cpu_flush && !cpu_clr_end) |=> (end_lock && !full));

    // R9: locked reads never raise underrun
    assert_no_unrun_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((start_lock || end_lock) && cpu_rd_en && !unrun) |=> !unrun);

    // R11: flush clears every flag
    assert_flush_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_flush && !eng_setup) |=> (empty && !full && !ovrun && !unrun && !start_lock && !end_lock));

    // R6: release empties the buffer
    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && cpu_rd_done && !eng_setup && !cpu_flush) |=> (!full && empty));

    // R7: lock flags and full are mutually exclusive
    assert_lock_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({full, start_lock, end_lock}));
endmodule

bind usb_rx_setup_fifo usb_rx_setup_fifo_chk u_chk (
    .clk(clk), .rst_n(rst_n), .eng_setup(eng_setup), .cpu_flush(cpu_flush),
    .cpu_rd_en(cpu_rd_en), .cpu_rd_done(cpu_rd_done), .cpu_clr_end(cpu_clr_end),
    .full(full), .empty(empty), .ovrun(ovrun), .unrun(unrun),
    .start_lock(start_lock), .end_lock(end_lock)
);

// File: tb/usb_rx_setup_fifo_tb_top.sv
`timescale 1ns/1ps
module usb_rx_setup_fifo_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic eng_wr_en = 0, eng_cnt_wr = 0, eng_ack = 0, eng_err = 0, eng_setup = 0;
    logic [7:0] eng_wr_data = 0;
    logic [3:0] eng_cnt = 0;
    logic cpu_rd_en = 0, cpu_rd_done = 0, cpu_flush = 0, cpu_clr_end = 0, cpu_clr_unrun = 0;
    logic [7:0] cpu_rd_data;
    logic [3:0] cpu_cnt;
    logic full, empty, ovrun, unrun, start_lock, end_lock;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    usb_rx_setup_fifo dut_i (
        .clk(clk), .rst_n(rst_n),
        .eng_wr_en(eng_wr_en), .eng_wr_data(eng_wr_data), .eng_cnt_wr(eng_cnt_wr),
        .eng_cnt(eng_cnt), .eng_ack(eng_ack), .eng_err(eng_err), .eng_setup(eng_setup),
        .cpu_rd_en(cpu_rd_en), .cpu_rd_done(cpu_rd_done), .cpu_flush(cpu_flush),
        .cpu_clr_end(cpu_clr_end), .cpu_clr_unrun(cpu_clr_unrun),
        .cpu_rd_data(cpu_rd_data), .cpu_cnt(cpu_cnt), .full(full), .empty(empty),
        .ovrun(ovrun), .unrun(unrun), .start_lock(start_lock), .end_lock(end_lock)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr_byte(input logic [7:0] b);
        eng_wr_en = 1; eng_wr_data = b; tick(); eng_wr_en = 0;
    endtask

    task automatic wr_cnt(input logic [3:0] c);
        eng_cnt_wr = 1; eng_cnt = c; tick(); eng_cnt_wr = 0;
    endtask

    task automatic ack();
        eng_ack = 1; tick(); eng_ack = 0;
    endtask

    task automatic rd_byte(output logic [7:0] d);
        cpu_rd_en = 1; tick(); cpu_rd_en = 0; d = cpu_rd_data;
    endtask

    task automatic release_pkt();
        cpu_rd_done = 1; tick(); cpu_rd_done = 0;
    endtask

    task automatic t_reset();
        check("R1 empty", empty, 1);
        check("R1 full", full, 0);
        check("R1 flags", {ovrun, unrun, start_lock, end_lock}, 0);
        check("R1 cnt", cpu_cnt, 0);
    endtask

    task automatic t_basic();
        logic [7:0] d;
        for (int i = 0; i < 5; i++) wr_byte(8'hA0 + 8'(i));
        check("R2 full before ack", full, 0);
        wr_cnt(4'd5);
        ack();
        check("R2 full", full, 1);
        check("R2 empty", empty, 0);
        check("R2 cnt", cpu_cnt, 5);
        for (int i = 0; i < 5; i++) begin
            rd_byte(d);
            check("R2 data", d, 8'hA0 + i);
        end
        check("R2 empty after reads", empty, 1);
        release_pkt();
        check("R6 full cleared", full, 0);
        check("R6 empty", empty, 1);
        check("R6 cnt", cpu_cnt, 0);
    endtask

    task automatic t_error();
        logic [7:0] d;
        for (int i = 0; i < 3; i++) wr_byte(8'h30 + 8'(i));
        eng_err = 1; tick(); eng_err = 0;
        check("R3 full stays 0", full, 0);
        wr_byte(8'h11); wr_byte(8'h22); wr_cnt(4'd2); ack();
        rd_byte(d); check("R3 first byte", d, 8'h11);
        rd_byte(d); check("R3 second byte", d, 8'h22);
        check("R3 empty after 2", empty, 1);
        release_pkt();
    endtask

    task automatic t_overrun();
        logic [7:0] d;
        wr_byte(8'h55); wr_cnt(4'd1); ack();
        wr_byte(8'h66);
        check("R4 ovrun set", ovrun, 1);
        rd_byte(d); check("R4 data kept", d, 8'h55);
        check("R4 pointer frozen", empty, 1);
        release_pkt();
        check("R4 sticky after release", ovrun, 1);
    endtask

    task automatic t_underrun();
        logic [7:0] d;
        rd_byte(d);
        check("R5 zero data", d, 0);
        check("R5 unrun set", unrun, 1);
        tick();
        check("R5 unrun sticky", unrun, 1);
        cpu_clr_unrun = 1; tick(); cpu_clr_unrun = 0;
        check("R5 unrun cleared", unrun, 0);
        wr_byte(8'h9C); wr_cnt(4'd1); ack();
        rd_byte(d);
        check("R5 pointer not moved", d, 8'h9C);
        release_pkt();
    endtask

    task automatic t_setup();
        logic [7:0] d;
        wr_byte(8'h77); wr_byte(8'h78); wr_cnt(4'd2); ack();
        rd_byte(d);
        eng_setup = 1; tick(); eng_setup = 0;
        check("R7 start lock", start_lock, 1);
        check("R7 full cleared", full, 0);
        check("R7 ovrun cleared", ovrun, 0);
        rd_byte(d);
        check("R9 locked read zero", d, 0);
        check("R9 no unrun", unrun, 0);
        for (int i = 0; i < 8; i++) wr_byte(8'h80 + 8'(i));
        wr_cnt(4'd8);
        ack();
        check("R8 start lowered", start_lock, 0);
        check("R8 end raised", end_lock, 1);
        check("R8 full stays 0", full, 0);
        release_pkt();
        check("R9 release ignored", end_lock, 1);
        rd_byte(d);
        check("R9 locked read zero 2", d, 0);
        cpu_clr_end = 1; tick(); cpu_clr_end = 0;
        check("R10 full", full, 1);
        check("R10 cnt", cpu_cnt, 8);
        for (int i = 0; i < 8; i++) begin
            rd_byte(d);
            check("R10 setup data", d, 8'h80 + i);
        end
        check("R10 empty after 8", empty, 1);
        release_pkt();
    endtask

    task automatic t_flush();
        logic [7:0] d;
        eng_setup = 1; cpu_flush = 1; tick(); eng_setup = 0; cpu_flush = 0;
        check("R7 setup beats flush", start_lock, 1);
        cpu_flush = 1; tick(); cpu_flush = 0;
        check("R11 lock cleared", {start_lock, end_lock}, 0);
        wr_byte(8'h42); wr_cnt(4'd1); ack(); wr_byte(8'h43);
        rd_byte(d); rd_byte(d);
        check("R11 pre flags", {ovrun, unrun}, 2'b11);
        cpu_flush = 1; tick(); cpu_flush = 0;
        check("R11 flags cleared", {full, ovrun, unrun, start_lock, end_lock}, 0);
        check("R11 empty", empty, 1);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_basic();
        t_error();
        t_overrun();
        t_underrun();
        t_setup();
        t_flush();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule